// File: doc/BRIEF.md
# Seconds Countdown Alarm

The block is a countdown alarm that software reaches through a small register port. Software loads a number of seconds, up to the full 32-bit range, and enables the counter. The counter then drops by one on each one-second tick. When the count steps from one to zero, a sticky pending flag is set. That flag drives the interrupt line if the interrupt is enabled, and drives the system wakeup line if wakeup routing is enabled. Software clears the flag by writing a one to it.

A second alarm, tied to the wall clock, is present only as registers. It has an enable, an interrupt enable and a write-one-to-clear pending flag. An external match pulse sets its flag; the compare logic that produces that pulse lives outside this block. To reload the counter, software first writes zero, waits, and then writes the new count. Every write to the load register takes effect at once, so that sequence needs no special handling in the block.

Top module: `alarm_countdown_top`

## Requirements
- R1: After reset every register reads 0, and irq_o and wakeup_o are low.
- R2: A write to offset 0x20 stores the load value, readable at 0x20, and sets the current count, readable at 0x24, in the same clock.
- R3: The count drops by exactly one on a clock where tick_i is high and enable bit 0 at 0x28 is set. Without a tick, or with the enable clear, the count holds.
- R4: A count of zero never decrements further, and loading zero never sets the pending flag.
- R5: The tick that moves the count from 1 to 0 sets pending bit 0 at 0x30 on that same clock.
- R6: Writing 1 to bit 0 at 0x30 clears the pending flag. Writing 0 leaves it unchanged.
- R7: irq_o is high while the counter pending flag and interrupt-enable bit 0 at 0x2C are both set. This holds whatever the counter enable is.
- R8: wakeup_o equals the counter pending flag ANDed with wakeup-routing bit 0 at 0x50.
- R9: The wall-clock alarm has enable bit 0 at 0x44, interrupt enable bit 0 at 0x48 and pending bit 0 at 0x4C. week_match_i sets that pending flag only while the enable is set. Writing 1 to the flag clears it. The flag drives irq_o when its interrupt enable is set.
- R10: A load write in the same clock as a tick wins: the count takes the written value.
- R11: The full 32-bit load value 0xFFFFFFFF reads back unchanged and decrements to 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| week_match_i | input | 1 | Match pulse from the external wall-clock compare |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt |
| wakeup_o | output | 1 | System wakeup request |

## Verification
The assertions check on every cycle that:
- a zero count does not wrap;
- a disabled counter holds its value;
- a load write lands exactly;
- an expiring tick always raises pending;
- the interrupt and wakeup lines never rise without a pending flag and its routing bit.

The directed scenarios cover what needs a history of register writes. These include write-one-to-clear against write-zero, the interrupt surviving a cleared counter enable, a zero load that never expires, a load colliding with a tick, and the gating of the wall-clock match by its enable.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef logic [7:0] reg_addr_t;

  localparam reg_addr_t OFS_LOAD    = 8'h20;
  localparam reg_addr_t OFS_CUR     = 8'h24;
  localparam reg_addr_t OFS_EN      = 8'h28;
  localparam reg_addr_t OFS_IE      = 8'h2C;
  localparam reg_addr_t OFS_PEND    = 8'h30;
  localparam reg_addr_t OFS_WK_EN   = 8'h44;
  localparam reg_addr_t OFS_WK_IE   = 8'h48;
  localparam reg_addr_t OFS_WK_PEND = 8'h4C;
  localparam reg_addr_t OFS_WAKE    = 8'h50;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_CNT = 0;
  localparam int unsigned SRC_WK  = 1;
endpackage

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = tick_i && en_i && (cnt_q != '0);
  // load wins over a same-cycle tick
  assign hit_o = !load_we_i && step && (cnt_q == ONE);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_we_i) cnt_q <= load_val_i;
    else if (step)      cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_addr_t         addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hit_i,
  input  logic              week_match_i,
  output logic              cnt_en_o,
  output logic              load_we_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] ie_o,
  output logic              wake_cfg_o
);
  logic [CNT_W-1:0]   load_q;
  logic               cnt_en_q, wk_en_q, wake_q;
  logic [NUM_SRC-1:0] ie_q, pend_q, set_vec, clr_vec;

  function automatic logic wr_hit(input reg_addr_t a);
    return wr_en_i && (addr_i == a);
  endfunction

  assign load_we_o  = wr_hit(OFS_LOAD);
  assign load_val_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '0;
      cnt_en_q <= 1'b0;
      wk_en_q  <= 1'b0;
      wake_q   <= 1'b0;
      ie_q     <= '0;
    end else begin
      if (wr_hit(OFS_LOAD))  load_q           <= wdata_i[CNT_W-1:0];
      if (wr_hit(OFS_EN))    cnt_en_q         <= wdata_i[0];
      if (wr_hit(OFS_WK_EN)) wk_en_q          <= wdata_i[0];
      if (wr_hit(OFS_WAKE))  wake_q           <= wdata_i[0];
      if (wr_hit(OFS_IE))    ie_q[SRC_CNT]    <= wdata_i[0];
      if (wr_hit(OFS_WK_IE)) ie_q[SRC_WK]     <= wdata_i[0];
    end
  end

  assign set_vec[SRC_CNT] = hit_i;
  assign set_vec[SRC_WK]  = week_match_i && wk_en_q;
  assign clr_vec[SRC_CNT] = wr_hit(OFS_PEND)    && wdata_i[0];
  assign clr_vec[SRC_WK]  = wr_hit(OFS_WK_PEND) && wdata_i[0];

  // sticky W1C flags, set has priority
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[g] <= 1'b0;
      else if (set_vec[g]) pend_q[g] <= 1'b1;
      else if (clr_vec[g]) pend_q[g] <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD:    rdata_o[CNT_W-1:0] = load_q;
      OFS_CUR:     rdata_o[CNT_W-1:0] = cnt_i;
      OFS_EN:      rdata_o[0] = cnt_en_q;
      OFS_IE:      rdata_o[0] = ie_q[SRC_CNT];
      OFS_PEND:    rdata_o[0] = pend_q[SRC_CNT];
      OFS_WK_EN:   rdata_o[0] = wk_en_q;
      OFS_WK_IE:   rdata_o[0] = ie_q[SRC_WK];
      OFS_WK_PEND: rdata_o[0] = pend_q[SRC_WK];
      OFS_WAKE:    rdata_o[0] = wake_q;
      default:     rdata_o = '0;
    endcase
  end

  assign cnt_en_o   = cnt_en_q;
  assign pend_o     = pend_q;
  assign ie_o       = ie_q;
  assign wake_cfg_o = wake_q;
endmodule

// File: rtl/alarm_countdown_top.sv
module alarm_countdown_top
  import alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              week_match_i,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wakeup_o
);
  logic [CNT_W-1:0]   cur_cnt, load_val;
  logic               cnt_en, load_we, hit, wake_cfg;
  logic [NUM_SRC-1:0] pend, ie;

  alarm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .cnt_i        (cur_cnt),
    .hit_i        (hit),
    .week_match_i (week_match_i),
    .cnt_en_o     (cnt_en),
    .load_we_o    (load_we),
    .load_val_o   (load_val),
    .pend_o       (pend),
    .ie_o         (ie),
    .wake_cfg_o   (wake_cfg)
  );

  alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (cnt_en),
    .load_we_i  (load_we),
    .load_val_i (load_val),
    .cnt_o      (cur_cnt),
    .hit_o      (hit)
  );

  assign irq_o    = |(pend & ie);
  assign wakeup_o = pend[SRC_CNT] & wake_cfg;
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cnt_en_i,
  input logic             load_we_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       pend_i,
  input logic [1:0]       ie_i,
  input logic             wake_cfg_i,
  input logic             irq_i,
  input logic             wakeup_i
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> cnt_i == $past(load_val_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !load_we_i) |=> $stable(cnt_i));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !load_we_i) |=> cnt_i == '0);

  p_expire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_en_i && !load_we_i && cnt_i == CNT_W'(1)) |=> pend_i[0]);

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ((pend_i[0] && ie_i[0]) || (pend_i[1] && ie_i[1])));

  p_wake_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_i |-> (pend_i[0] && wake_cfg_i));
endmodule

bind alarm_countdown_top alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cnt_en_i   (cnt_en),
  .load_we_i  (load_we),
  .load_val_i (load_val),
  .cnt_i      (cur_cnt),
  .pend_i     (pend),
  .ie_i       (ie),
  .wake_cfg_i (wake_cfg),
  .irq_i      (irq_o),
  .wakeup_i   (wakeup_o)
);

// File: tb/tb_alarm_countdown_top.sv
module tb_alarm_countdown_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wmatch = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alarm_countdown_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .week_match_i(wmatch),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .wakeup_o(wake));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic with_tick = 1'b0);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [7:0] offs [9] = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h44, 8'h48, 8'h4C, 8'h50};
    foreach (offs[i]) begin rd_reg(offs[i], v); chk("R1 reg", v, 0); end
    chk("R1 irq", irq, 0);
    chk("R1 wakeup", wake, 0);
  endtask

  task automatic t_load_and_count();
    logic [31:0] v;
    wr_reg(8'h20, 5);
    rd_reg(8'h20, v); chk("R2 load readback", v, 5);
    rd_reg(8'h24, v); chk("R2 current", v, 5);
    ticks(3);
    rd_reg(8'h24, v); chk("R3 disabled hold", v, 5);
    wr_reg(8'h28, 1);
    ticks(2);
    rd_reg(8'h24, v); chk("R3 two ticks", v, 3);
    repeat (5) @(negedge clk);
    rd_reg(8'h24, v); chk("R3 no tick hold", v, 3);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr_reg(8'h2C, 1);
    wr_reg(8'h50, 1);
    ticks(2);
    rd_reg(8'h30, v); chk("R5 not yet pending at 1", v, 0);
    chk("R7 irq low before expiry", irq, 0);
    ticks(1);
    rd_reg(8'h24, v); chk("R5 count zero", v, 0);
    rd_reg(8'h30, v); chk("R5 pending set", v, 1);
    chk("R7 irq high", irq, 1);
    chk("R8 wakeup high", wake, 1);
    ticks(3);
    rd_reg(8'h24, v); chk("R4 no underflow", v, 0);
    wr_reg(8'h28, 0);
    chk("R7 irq independent of counter enable", irq, 1);
    wr_reg(8'h50, 0);
    chk("R8 wakeup off when routing clear", wake, 0);
    chk("R7 irq stays with routing clear", irq, 1);
    wr_reg(8'h30, 0);
    rd_reg(8'h30, v); chk("R6 write 0 keeps pending", v, 1);
    wr_reg(8'h30, 1);
    rd_reg(8'h30, v); chk("R6 W1C clears", v, 0);
    chk("R7 irq low after clear", irq, 0);
  endtask

  task automatic t_zero_load();
    logic [31:0] v;
    wr_reg(8'h28, 1);
    wr_reg(8'h20, 0);
    ticks(3);
    rd_reg(8'h30, v); chk("R4 zero load no pending", v, 0);
    chk("R4 zero load no irq", irq, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr_reg(8'h20, 7);
    wr_reg(8'h20, 9, 1'b1);
    rd_reg(8'h24, v); chk("R10 load wins over tick", v, 9);
    wr_reg(8'h20, 1);
    wr_reg(8'h20, 4, 1'b1);
    rd_reg(8'h30, v); chk("R10 no expiry on colliding load", v, 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_reg(8'h20, v); chk("R11 full load readback", v, 32'hFFFF_FFFF);
    ticks(1);
    rd_reg(8'h24, v); chk("R11 full decrement", v, 32'hFFFF_FFFE);
    wr_reg(8'h28, 0);
  endtask

  task automatic t_week();
    logic [31:0] v;
    wr_reg(8'h2C, 0);
    @(negedge clk); wmatch = 1'b1; @(negedge clk); wmatch = 1'b0;
    rd_reg(8'h4C, v); chk("R9 match ignored when disabled", v, 0);
    wr_reg(8'h44, 1);
    @(negedge clk); wmatch = 1'b1; @(negedge clk); wmatch = 1'b0;
    rd_reg(8'h4C, v); chk("R9 match sets pending", v, 1);
    chk("R9 irq off without week ie", irq, 0);
    chk("R9 wakeup unaffected", wake, 0);
    wr_reg(8'h48, 1);
    chk("R9 irq with week ie", irq, 1);
    wr_reg(8'h4C, 1);
    rd_reg(8'h4C, v); chk("R9 W1C clears", v, 0);
    chk("R9 irq low after clear", irq, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_load_and_count();
    t_expire();
    t_zero_load();
    t_collide();
    t_full();
    t_week();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule